// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides which of two masters drives the local bus: the internal bus-cycle logic, or an external master that asks for the bus through a hold request. The hold request is a synchronous active-high level that is sampled on each rising clock edge. When the request is seen and the internal side is quiet, the block gives up the bus in steps. No cycle may be in flight, no locked sequence may be open, and no DMA transfer may be running. The first step floats the address, data, status, strobe, byte-enable and direction drivers. One clock later the step parks every chip select inactive. One clock after that it raises the acknowledge.

The bus is taken back in the reverse order. The acknowledge falls first. The drivers are re-enabled and the chip selects are released one clock later, so the two masters never drive the bus together. The bus is taken back when the external master drops its request, or when an internal refresh request arrives. A refresh request takes priority over hold, so the acknowledge can fall while hold is still high. After a refresh, a hold request that is still asserted is not granted again until the refresh reports completion.

All pins are plain control levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `hold_arb`

## Requirements
- R1: In reset and in the first cycle after reset, hold_ack is 0, every bit of bus_oe is 1 and every bit of cs_park is 0.
- R2: If hold_req is 1 at edge N while cyc_busy, lock_active and dma_busy are all 0, then bus_oe goes to all 0 after edge N+1. cs_park goes to all 1 after edge N+2, and hold_ack goes to 1 after edge N+3. This holds only if hold_req stays 1 and no refresh is pending.
- R3: The drivers are never floated while cyc_busy, lock_active or dma_busy is 1. The release starts at the first edge where all three are 0 and hold_req is still 1.
- R4: cs_park rises exactly one clock after bus_oe falls, and hold_ack rises exactly one clock after cs_park rises.
- R5: If hold_req is 0 at an edge while hold_ack is 1, then hold_ack is 0 after that edge. bus_oe returns to all 1 and cs_park to all 0 one edge later.
- R6: A refresh_req pulse seen while granted, or in the last release step, makes hold_ack 0 after that edge, and the bus is taken back as in R5. A refresh_req seen while waiting aborts the wait. A still-high hold_req is not acted on until the edge after refresh_done is seen.
- R7: If hold_req falls before the release starts, the internal side keeps the bus: bus_oe stays 1 and cs_park stays 0.
- R8: If hold_req falls while the drivers are already floated, the chip-select park step still happens. The bus is then taken back as in R5 with hold_ack never rising.
- R9: While hold_ack is 1, every bit of bus_oe is 0 and every bit of cs_park is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | External master requests the bus (level) |
| cyc_busy | input | 1 | An internal bus cycle is in progress |
| lock_active | input | 1 | A locked transfer sequence is open |
| dma_busy | input | 1 | A DMA transfer is in progress |
| refresh_req | input | 1 | Refresh needs the bus (pulse or level) |
| refresh_done | input | 1 | The refresh cycle has completed (pulse) |
| hold_ack | output | 1 | The bus is granted to the external master |
| bus_oe | output | NUM_OE | Driver enables for the bus signal groups, 1 = driven |
| cs_park | output | NUM_CS | Chip-select park controls, 1 = force inactive high |

## Verification
The checks assume that the busy, lock and DMA inputs describe the internal side honestly. In particular, no internal cycle starts while the drivers are floated. They also assume that refresh_done follows a refresh request and is never seen on its own. The stimulus drives every input at the falling clock edge and holds cyc_busy, lock_active and dma_busy at 0 once the release has begun. It pulses refresh_done only after a refresh request. Lock and DMA windows up to sixteen clocks are tried, which matches the worst-case word transfer.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [2:0] {
    ST_OWNED     = 3'd0,
    ST_WAIT_END  = 3'd1,
    ST_REL_TRI   = 3'd2,
    ST_REL_CS    = 3'd3,
    ST_GRANTED   = 3'd4,
    ST_RECLAIM   = 3'd5
  } arb_st_e;
endpackage

// File: rtl/hold_arb_refresh_guard.sv
module hold_arb_refresh_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_req,
  input  logic refresh_done,
  output logic refresh_block
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (refresh_req)  pend_q <= 1'b1;
    else if (refresh_done) pend_q <= 1'b0;
  end

  assign refresh_block = refresh_req | pend_q;
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold_req,
  input  logic    bus_quiet,
  input  logic    refresh_block,
  output arb_st_e state
);
  arb_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OWNED:    if (hold_req && !refresh_block) nxt = ST_WAIT_END;
      ST_WAIT_END: begin
        if (!hold_req || refresh_block) nxt = ST_OWNED;
        else if (bus_quiet)             nxt = ST_REL_TRI;
      end
      ST_REL_TRI:  nxt = ST_REL_CS;
      ST_REL_CS:   nxt = (hold_req && !refresh_block) ? ST_GRANTED : ST_RECLAIM;
      ST_GRANTED:  if (!hold_req || refresh_block) nxt = ST_RECLAIM;
      ST_RECLAIM:  nxt = ST_OWNED;
      default:     nxt = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OWNED;
    else        state <= nxt;
  end
endmodule

// File: rtl/hold_arb_outdec.sv
module hold_arb_outdec
  import hold_arb_pkg::*;
#(
  parameter int NUM_OE = 6,
  parameter int NUM_CS = 8
) (
  input  arb_st_e           state,
  output logic              hold_ack,
  output logic [NUM_OE-1:0] bus_oe,
  output logic [NUM_CS-1:0] cs_park
);
  logic drive, park;

  assign drive    = (state == ST_OWNED) || (state == ST_WAIT_END);
  assign park     = (state == ST_REL_CS) || (state == ST_GRANTED) || (state == ST_RECLAIM);
  assign hold_ack = (state == ST_GRANTED);

  for (genvar g = 0; g < NUM_OE; g++) begin : g_oe
    assign bus_oe[g] = drive;
  end
  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_park[c] = park;
  end
endmodule

// File: rtl/hold_arb.sv
module hold_arb
  import hold_arb_pkg::*;
#(
  parameter int NUM_OE = 6,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  input  logic              cyc_busy,
  input  logic              lock_active,
  input  logic              dma_busy,
  input  logic              refresh_req,
  input  logic              refresh_done,
  output logic              hold_ack,
  output logic [NUM_OE-1:0] bus_oe,
  output logic [NUM_CS-1:0] cs_park
);
  arb_st_e state;
  logic    refresh_block;
  logic    bus_quiet;

  assign bus_quiet = !cyc_busy && !lock_active && !dma_busy;

  hold_arb_refresh_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_req  (refresh_req),
    .refresh_done (refresh_done),
    .refresh_block(refresh_block)
  );

  hold_arb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req     (hold_req),
    .bus_quiet    (bus_quiet),
    .refresh_block(refresh_block),
    .state        (state)
  );

  hold_arb_outdec #(.NUM_OE(NUM_OE), .NUM_CS(NUM_CS)) u_dec (
    .state   (state),
    .hold_ack(hold_ack),
    .bus_oe  (bus_oe),
    .cs_park (cs_park)
  );
endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk #(
  parameter int NUM_OE = 6,
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_req,
  input logic              cyc_busy,
  input logic              lock_active,
  input logic              dma_busy,
  input logic              refresh_req,
  input logic              hold_ack,
  input logic [NUM_OE-1:0] bus_oe,
  input logic [NUM_CS-1:0] cs_park
);
  AST_RESET_OWNED: assert property (@(posedge clk) !rst_n |=> !hold_ack && (&bus_oe) && !(|cs_park)); // R1
  AST_NO_FLOAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe[0]) |-> $past(!cyc_busy && !lock_active && !dma_busy && hold_req)); // R3
  AST_CS_AFTER_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_park[0]) |-> $past(bus_oe == '0) && $past(cs_park == '0)); // R4
  AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(cs_park == '1) && $past(!hold_ack)); // R4
  AST_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack); // R5
  AST_REENABLE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe[0]) |-> !hold_ack && !$past(hold_ack)); // R5
  AST_REFRESH_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !hold_ack); // R6
  AST_GRANT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (bus_oe == '0) && (cs_park == '1)); // R9
endmodule

bind hold_arb hold_arb_chk #(.NUM_OE(NUM_OE), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
  .lock_active(lock_active), .dma_busy(dma_busy), .refresh_req(refresh_req),
  .hold_ack(hold_ack), .bus_oe(bus_oe), .cs_park(cs_park)
);

// File: tb/test_hold_arb.sv
`timescale 1ns/1ps
module test_hold_arb;
  localparam int NUM_OE = 6;
  localparam int NUM_CS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req = 0, cyc_busy = 0, lock_active = 0, dma_busy = 0;
  logic refresh_req = 0, refresh_done = 0;
  logic hold_ack;
  logic [NUM_OE-1:0] bus_oe;
  logic [NUM_CS-1:0] cs_park;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic ack; logic oe; logic cs; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  hold_arb #(.NUM_OE(NUM_OE), .NUM_CS(NUM_CS)) i_hold_arb (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
    .lock_active(lock_active), .dma_busy(dma_busy), .refresh_req(refresh_req),
    .refresh_done(refresh_done), .hold_ack(hold_ack), .bus_oe(bus_oe), .cs_park(cs_park)
  );

  task automatic compare(input logic ea, input logic eo, input logic ec, input string tag);
    logic [NUM_OE-1:0] eov;
    logic [NUM_CS-1:0] ecv;
    eov = {NUM_OE{eo}};
    ecv = {NUM_CS{ec}};
    checks++;
    if (hold_ack !== ea || bus_oe !== eov || cs_park !== ecv) begin
      failures++;
      $display("FAIL %s: ack=%b oe=%b cs=%b expected ack=%b oe=%b cs=%b",
               tag, hold_ack, bus_oe, cs_park, ea, eov, ecv);
    end
  endtask

  // monitor: compares results of each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.ack, e.oe, e.cs, e.tag);
    end
  end

  // outcome codes: O owned, T floated, C parked, G granted, R reclaiming
  task automatic step(input logic h, input logic b, input logic l, input logic d,
                      input logic rq, input logic rd, input byte code, input string tag);
    exp_t e;
    @(negedge clk);
    hold_req = h; cyc_busy = b; lock_active = l; dma_busy = d;
    refresh_req = rq; refresh_done = rd;
    e.tag = tag;
    case (code)
      "O": begin e.ack = 0; e.oe = 1; e.cs = 0; end
      "T": begin e.ack = 0; e.oe = 0; e.cs = 0; end
      "G": begin e.ack = 1; e.oe = 0; e.cs = 1; end
      default: begin e.ack = 0; e.oe = 0; e.cs = 1; end
    endcase
    sb.push_back(e);
  endtask

  task automatic release_back(input string tag);
    step(0,0,0,0,0,0,"R",tag);
    step(0,0,0,0,0,0,"O",tag);
  endtask

  task automatic grant_tail(input string tag);
    step(1,0,0,0,0,0,"T",tag);
    step(1,0,0,0,0,0,"C",tag);
    step(1,0,0,0,0,0,"G",tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 compare(0, 1, 0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2 compare(0, 1, 0, "R1 after reset");

    // basic grant and release
    step(1,0,0,0,0,0,"O","R2 wait");
    grant_tail("R2 R4 grant");
    step(1,0,0,0,0,0,"G","R9 held");
    release_back("R5 reclaim");

    // busy cycle defers release
    step(1,1,0,0,0,0,"O","R3 busy");
    step(1,1,0,0,0,0,"O","R3 busy");
    step(1,0,0,0,0,0,"T","R3 busy end");
    step(1,0,0,0,0,0,"C","R4");
    step(1,0,0,0,0,0,"G","R4");
    release_back("R5");

    // locked sequence
    for (int i = 0; i < 4; i++) step(1,0,1,0,0,0,"O","R3 lock");
    step(1,0,0,0,0,0,"T","R3 lock end");
    step(1,0,0,0,0,0,"C","R4");
    step(1,0,0,0,0,0,"G","R4");
    release_back("R5");

    // 16-clock DMA word transfer
    for (int i = 0; i < 16; i++) step(1,0,0,1,0,0,"O","R3 dma");
    step(1,0,0,0,0,0,"T","R3 dma end");
    step(1,0,0,0,0,0,"C","R4");
    step(1,0,0,0,0,0,"G","R4");

    // refresh preempts while hold stays high
    step(1,0,0,0,1,0,"R","R6 preempt");
    step(1,0,0,0,0,0,"O","R6 back");
    step(1,0,0,0,0,0,"O","R6 blocked");
    step(1,0,0,0,0,0,"O","R6 blocked");
    step(1,0,0,0,0,1,"O","R6 done seen");
    step(1,0,0,0,0,0,"O","R6 wait");
    grant_tail("R6 regrant");
    release_back("R5");

    // refresh aborts a wait
    step(1,1,0,0,0,0,"O","R6 wait");
    step(1,1,0,0,1,0,"O","R6 abort");
    step(1,0,0,0,0,0,"O","R6 blocked");
    step(1,0,0,0,0,1,"O","R6 done");
    step(0,0,0,0,0,0,"O","R7");

    // hold withdrawn before release
    step(1,1,0,0,0,0,"O","R7 wait");
    step(0,1,0,0,0,0,"O","R7 drop");
    step(0,0,0,0,0,0,"O","R7 stays owned");
    step(0,0,0,0,0,0,"O","R7 stays owned");

    // hold withdrawn mid-release
    step(1,0,0,0,0,0,"O","R8 wait");
    step(1,0,0,0,0,0,"T","R8 float");
    step(0,0,0,0,0,0,"C","R8 park anyway");
    step(0,0,0,0,0,0,"R","R8 no ack");
    step(0,0,0,0,0,0,"O","R8 back");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule